// File: doc/BRIEF.md
# Single-Precision Floating-Point Adder

This block adds or subtracts two 32-bit binary floating-point operands. Each operand has a sign bit, an 8-bit exponent biased by 127, and a 23-bit fraction. The operation is chosen per operation by a subtract select, which flips the sign of the second operand before a signed-magnitude add.

The datapath is pipelined and accepts one operation per cycle. The first stage classifies both operands, finds the larger magnitude and shifts the smaller significand right, keeping guard, round and sticky bits. The second stage adds or subtracts the significands and normalizes the sum in either direction. The last stage rounds to nearest with ties to even, renormalizes after a rounding carry, and packs the result. Special encodings are handled throughout: zeros, denormals, infinities and NaNs.

Three flags come with each result: overflow, underflow and invalid. Each result appears with a valid strobe a fixed number of cycles after its operands.

Top module: `fp_add_sp`

## Requirements
- R1: With the default parameters, `out_vld` rises exactly 3 clock cycles after the cycle in which `in_vld` is sampled high. A new operation can be issued every cycle. Out of reset, `out_vld`, `res` and all flags are 0.
- R2: For finite operands, `res` is the exact sum rounded to nearest, with ties to even.
- R3: With `op_sub`=1 the result is `op_a` minus `op_b`, produced by inverting bit 31 of `op_b` and adding. In an effective subtraction the result takes the sign of the operand with the larger magnitude.
- R4: Alignment keeps guard, round and sticky bits, so a shifted-out part just above one half ulp rounds up. A rounding carry out of the significand increments the exponent. For example, 0x4B7FFFFF plus 0x3F000000 gives 0x4B800000.
- R5: An exact zero from operands of opposite sign is +0 (0x00000000). The sum of two negative zeros is -0 (0x80000000).
- R6: An operand with exponent field 0 has no implied leading 1. A nonzero result below the normal range is delivered as a denormal (exponent field 0) with `unf`=1.
- R7: If the rounded result of finite operands exceeds the largest finite value, the result is infinity of the result's sign (exponent field 0xFF, fraction 0) with `ovf`=1.
- R8: Infinity plus a finite value returns that infinity. Infinity minus infinity (an effective subtraction) returns 0x7FC00000 with `inv`=1.
- R9: Any NaN operand (exponent 0xFF, nonzero fraction) gives 0x7FC00000. `inv` is 1 only when a NaN operand has fraction bit 22 clear.
- R10: For any valid result, at most one of `ovf`, `unf` and `inv` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_vld | input | 1 | Operands are presented this cycle |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| op_sub | input | 1 | 1 selects op_a minus op_b, 0 selects op_a plus op_b |
| out_vld | output | 1 | Result and flags are valid |
| res | output | 32 | Rounded result |
| ovf | output | 1 | Result overflowed to infinity |
| unf | output | 1 | Result is a nonzero denormal |
| inv | output | 1 | Invalid operation; result is the canonical NaN |

## Verification
A corrupted sticky or guard bit in the alignment stage shows up as a one-ulp error on results near a rounding tie. It appears at `res` three cycles after the operands are issued. A wrong normalization shift count shows as a result whose exponent is off and whose fraction is shifted, again three cycles later. A broken valid pipeline shows as a result whose issue-to-output spacing is not three cycles. The bench therefore checks both the value and the arrival cycle of every result. A misplaced special-case decode shows as a wrong infinity or NaN encoding, or as a wrong flag on that same result.

// File: rtl/fpa_pkg.sv
package fpa_pkg;
   // classification of one unpacked operand
   typedef enum logic [1:0] {
      FC_ZERO   = 2'd0,
      FC_FINITE = 2'd1,
      FC_INF    = 2'd2,
      FC_NAN    = 2'd3
   } fpa_cls_e;
endpackage

// File: rtl/fpa_stage.sv
// Optional pipeline register: a parameter selects a flop stage or a wire.
module fpa_stage #(
   parameter int WIDTH = 8,
   parameter int EN    = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_vld,
   input  logic [WIDTH-1:0] in_dat,
   output logic             out_vld,
   output logic [WIDTH-1:0] out_dat
);
   generate
      if (EN != 0) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) out_vld <= 1'b0;
            else        out_vld <= in_vld;
         end
         always_ff @(posedge clk) begin
            if (in_vld) out_dat <= in_dat;
         end
      end else begin : g_wire
         assign out_vld = in_vld;
         assign out_dat = in_dat;
      end
   endgenerate
endmodule

// File: rtl/fpa_align.sv
// Unpack, classify, order by magnitude and align the smaller significand.
module fpa_align #(
   parameter int EXP_W = 8,
   parameter int FRC_W = 23,
   localparam int W  = 1 + EXP_W + FRC_W,
   localparam int SW = FRC_W + 4,
   localparam int EW = EXP_W + 2
) (
   input  logic [W-1:0]  op_a,
   input  logic [W-1:0]  op_b,
   input  logic          op_sub,
   output logic          spec_vld,
   output logic [W-1:0]  spec_res,
   output logic          spec_inv,
   output logic          res_sign,
   output logic          zero_sign,
   output logic          eff_sub,
   output logic [EW-1:0] big_exp,
   output logic [SW-1:0] big_sig,
   output logic [SW-1:0] sml_sig
);
   import fpa_pkg::*;

   localparam int DW = $clog2(SW + 1);
   localparam logic [EXP_W-1:0] EXP_ONES = '1;
   localparam logic [W-1:0] QNAN = {1'b0, EXP_ONES, 1'b1, {(FRC_W-1){1'b0}}};

   logic [W-1:0]     opnd  [2];
   logic             sgn   [2];
   logic [EXP_W-1:0] exf   [2];
   logic [FRC_W-1:0] frc   [2];
   fpa_cls_e         cls   [2];
   logic             quiet [2];
   logic [EW-1:0]    eeff  [2];
   logic [FRC_W:0]   sig   [2];

   assign opnd[0] = op_a;
   assign opnd[1] = {op_b[W-1] ^ op_sub, op_b[W-2:0]};

   generate
      for (genvar gk = 0; gk < 2; gk++) begin : g_unpack
         assign sgn[gk]   = opnd[gk][W-1];
         assign exf[gk]   = opnd[gk][W-2:FRC_W];
         assign frc[gk]   = opnd[gk][FRC_W-1:0];
         assign quiet[gk] = frc[gk][FRC_W-1];
         assign cls[gk]   = (exf[gk] == '0)       ? ((frc[gk] == '0) ? FC_ZERO : FC_FINITE) :
                            (exf[gk] == EXP_ONES) ? ((frc[gk] == '0) ? FC_INF  : FC_NAN)    :
                                                    FC_FINITE;
         // denormals share the scale of exponent 1 but carry no hidden bit
         assign eeff[gk]  = (exf[gk] == '0) ? EW'(1) : EW'(exf[gk]);
         assign sig[gk]   = {exf[gk] != '0, frc[gk]};
      end
   endgenerate

   // magnitude order: exponent then fraction, as one unsigned compare
   logic swap;
   assign swap = opnd[1][W-2:0] > opnd[0][W-2:0];

   logic [EW-1:0]  sml_exp;
   logic [FRC_W:0] sml_raw;
   logic [EW-1:0]  diff;
   logic [DW-1:0]  dcl;
   logic [SW-1:0]  ext, shr;
   logic           lost;

   assign big_exp = swap ? eeff[1] : eeff[0];
   assign sml_exp = swap ? eeff[0] : eeff[1];
   assign big_sig = {(swap ? sig[1] : sig[0]), 3'b000};
   assign sml_raw = swap ? sig[0] : sig[1];

   assign diff = big_exp - sml_exp;
   assign dcl  = (diff > EW'(SW)) ? DW'(SW) : DW'(diff);
   assign ext  = {sml_raw, 3'b000};
   assign shr  = ext >> dcl;
   assign lost = |(ext & ~({SW{1'b1}} << dcl));
   assign sml_sig = {shr[SW-1:1], shr[0] | lost};

   assign res_sign  = swap ? sgn[1] : sgn[0];
   assign zero_sign = sgn[0] & sgn[1];
   assign eff_sub   = sgn[0] ^ sgn[1];

   always_comb begin
      spec_vld = 1'b0;
      spec_res = QNAN;
      spec_inv = 1'b0;
      if (cls[0] == FC_NAN || cls[1] == FC_NAN) begin
         spec_vld = 1'b1;
         spec_inv = (cls[0] == FC_NAN && !quiet[0]) || (cls[1] == FC_NAN && !quiet[1]);
      end else if (cls[0] == FC_INF && cls[1] == FC_INF && eff_sub) begin
         spec_vld = 1'b1;
         spec_inv = 1'b1;
      end else if (cls[0] == FC_INF) begin
         spec_vld = 1'b1;
         spec_res = {sgn[0], EXP_ONES, {FRC_W{1'b0}}};
      end else if (cls[1] == FC_INF) begin
         spec_vld = 1'b1;
         spec_res = {sgn[1], EXP_ONES, {FRC_W{1'b0}}};
      end
   end
endmodule

// File: rtl/fpa_addnorm.sv
// Signed-magnitude significand add and normalization in both directions.
module fpa_addnorm #(
   parameter int EXP_W = 8,
   parameter int FRC_W = 23,
   localparam int SW = FRC_W + 4,
   localparam int EW = EXP_W + 2
) (
   input  logic          eff_sub,
   input  logic [EW-1:0] big_exp,
   input  logic [SW-1:0] big_sig,
   input  logic [SW-1:0] sml_sig,
   output logic [EW-1:0] nrm_exp,
   output logic [SW-1:0] nrm_sig
);
   localparam int DW = $clog2(SW + 1);

   logic [SW:0]   sum;
   logic [DW-1:0] lz, sh;
   logic [EW-1:0] lim;

   assign sum = eff_sub ? ({1'b0, big_sig} - {1'b0, sml_sig})
                        : ({1'b0, big_sig} + {1'b0, sml_sig});

   // leading-zero count of the in-range part; highest set bit wins
   always_comb begin
      lz = DW'(SW);
      for (int i = 0; i < SW; i++) begin
         if (sum[i]) lz = DW'(SW - 1 - i);
      end
   end

   // never shift below the smallest exponent: the rest stays denormal
   assign lim = big_exp - EW'(1);
   assign sh  = (EW'(lz) < lim) ? lz : DW'(lim);

   always_comb begin
      if (sum[SW]) begin
         nrm_sig = {sum[SW:2], |sum[1:0]};
         nrm_exp = big_exp + EW'(1);
      end else begin
         nrm_sig = sum[SW-1:0] << sh;
         nrm_exp = big_exp - EW'(sh);
      end
   end
endmodule

// File: rtl/fpa_round.sv
// Round to nearest even, renormalize on carry, range check and pack.
module fpa_round #(
   parameter int EXP_W = 8,
   parameter int FRC_W = 23,
   localparam int W  = 1 + EXP_W + FRC_W,
   localparam int SW = FRC_W + 4,
   localparam int EW = EXP_W + 2
) (
   input  logic [EW-1:0] nrm_exp,
   input  logic [SW-1:0] nrm_sig,
   input  logic          res_sign,
   input  logic          zero_sign,
   input  logic          spec_vld,
   input  logic [W-1:0]  spec_res,
   input  logic          spec_inv,
   output logic [W-1:0]  res,
   output logic          ovf,
   output logic          unf,
   output logic          inv
);
   localparam logic [EXP_W-1:0] EXP_ONES = '1;
   localparam logic [EW-1:0]    EMAX     = EW'(EXP_ONES);

   logic [FRC_W:0]   mant, mf;
   logic [FRC_W+1:0] inc;
   logic             grd, rsb, up;
   logic [EW-1:0]    ex;

   assign mant = nrm_sig[SW-1:3];
   assign grd  = nrm_sig[2];
   assign rsb  = |nrm_sig[1:0];
   assign up   = grd & (rsb | mant[0]);
   assign inc  = {1'b0, mant} + (FRC_W+2)'(up);
   assign mf   = inc[FRC_W+1] ? inc[FRC_W+1:1] : inc[FRC_W:0];
   assign ex   = inc[FRC_W+1] ? nrm_exp + EW'(1) : nrm_exp;

   always_comb begin
      res = '0;
      ovf = 1'b0;
      unf = 1'b0;
      inv = 1'b0;
      if (spec_vld) begin
         res = spec_res;
         inv = spec_inv;
      end else if (mf == '0) begin
         res = {zero_sign, {(W-1){1'b0}}};
      end else if (mf[FRC_W]) begin
         if (ex >= EMAX) begin
            res = {res_sign, EXP_ONES, {FRC_W{1'b0}}};
            ovf = 1'b1;
         end else begin
            res = {res_sign, ex[EXP_W-1:0], mf[FRC_W-1:0]};
         end
      end else begin
         res = {res_sign, {EXP_W{1'b0}}, mf[FRC_W-1:0]};
         unf = 1'b1;
      end
   end
endmodule

// File: rtl/fp_add_sp.sv
// Pipelined floating-point adder/subtractor, round to nearest even.
module fp_add_sp #(
   parameter int EXP_W     = 8,
   parameter int FRC_W     = 23,
   parameter int REG_ALIGN = 1,
   parameter int REG_NORM  = 1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     in_vld,
   input  logic [EXP_W+FRC_W:0]     op_a,
   input  logic [EXP_W+FRC_W:0]     op_b,
   input  logic                     op_sub,
   output logic                     out_vld,
   output logic [EXP_W+FRC_W:0]     res,
   output logic                     ovf,
   output logic                     unf,
   output logic                     inv
);
   localparam int W   = 1 + EXP_W + FRC_W;
   localparam int SW  = FRC_W + 4;
   localparam int EW  = EXP_W + 2;
   localparam int AW  = 5 + W + EW + 2 * SW;
   localparam int BW  = 4 + W + EW + SW;

   generate
      if (EXP_W < 3 || EXP_W > 15) begin : g_bad_exp
         $error("fp_add_sp: EXP_W out of range");
      end
      if (FRC_W < 2) begin : g_bad_frc
         $error("fp_add_sp: FRC_W too small");
      end
      if (REG_ALIGN < 0 || REG_ALIGN > 1 || REG_NORM < 0 || REG_NORM > 1) begin : g_bad_reg
         $error("fp_add_sp: stage enables must be 0 or 1");
      end
   endgenerate

   // ---------------- stage A: classify and align ----------------
   logic          a_spec_vld, a_spec_inv, a_res_sign, a_zero_sign, a_eff_sub;
   logic [W-1:0]  a_spec_res;
   logic [EW-1:0] a_big_exp;
   logic [SW-1:0] a_big_sig, a_sml_sig;

   fpa_align #(.EXP_W(EXP_W), .FRC_W(FRC_W)) u_align (
      .op_a      (op_a),
      .op_b      (op_b),
      .op_sub    (op_sub),
      .spec_vld  (a_spec_vld),
      .spec_res  (a_spec_res),
      .spec_inv  (a_spec_inv),
      .res_sign  (a_res_sign),
      .zero_sign (a_zero_sign),
      .eff_sub   (a_eff_sub),
      .big_exp   (a_big_exp),
      .big_sig   (a_big_sig),
      .sml_sig   (a_sml_sig)
   );

   logic [AW-1:0] a_bus, a_q;
   logic          a_vld;
   assign a_bus = {a_spec_vld, a_spec_res, a_spec_inv, a_res_sign, a_zero_sign,
                   a_eff_sub, a_big_exp, a_big_sig, a_sml_sig};

   fpa_stage #(.WIDTH(AW), .EN(REG_ALIGN)) u_st_a (
      .clk     (clk),
      .rst_n   (rst_n),
      .in_vld  (in_vld),
      .in_dat  (a_bus),
      .out_vld (a_vld),
      .out_dat (a_q)
   );

   // ---------------- stage B: add and normalize ----------------
   logic          b_spec_vld, b_spec_inv, b_res_sign, b_zero_sign, b_eff_sub;
   logic [W-1:0]  b_spec_res;
   logic [EW-1:0] b_big_exp, b_nrm_exp;
   logic [SW-1:0] b_big_sig, b_sml_sig, b_nrm_sig;

   assign {b_spec_vld, b_spec_res, b_spec_inv, b_res_sign, b_zero_sign,
           b_eff_sub, b_big_exp, b_big_sig, b_sml_sig} = a_q;

   fpa_addnorm #(.EXP_W(EXP_W), .FRC_W(FRC_W)) u_addnorm (
      .eff_sub (b_eff_sub),
      .big_exp (b_big_exp),
      .big_sig (b_big_sig),
      .sml_sig (b_sml_sig),
      .nrm_exp (b_nrm_exp),
      .nrm_sig (b_nrm_sig)
   );

   logic [BW-1:0] b_bus, b_q;
   logic          b_vld;
   assign b_bus = {b_spec_vld, b_spec_res, b_spec_inv, b_res_sign, b_zero_sign,
                   b_nrm_exp, b_nrm_sig};

   fpa_stage #(.WIDTH(BW), .EN(REG_NORM)) u_st_b (
      .clk     (clk),
      .rst_n   (rst_n),
      .in_vld  (a_vld),
      .in_dat  (b_bus),
      .out_vld (b_vld),
      .out_dat (b_q)
   );

   // ---------------- stage C: round and pack ----------------
   logic          c_spec_vld, c_spec_inv, c_res_sign, c_zero_sign;
   logic [W-1:0]  c_spec_res, c_res;
   logic [EW-1:0] c_nrm_exp;
   logic [SW-1:0] c_nrm_sig;
   logic          c_ovf, c_unf, c_inv;

   assign {c_spec_vld, c_spec_res, c_spec_inv, c_res_sign, c_zero_sign,
           c_nrm_exp, c_nrm_sig} = b_q;

   fpa_round #(.EXP_W(EXP_W), .FRC_W(FRC_W)) u_round (
      .nrm_exp   (c_nrm_exp),
      .nrm_sig   (c_nrm_sig),
      .res_sign  (c_res_sign),
      .zero_sign (c_zero_sign),
      .spec_vld  (c_spec_vld),
      .spec_res  (c_spec_res),
      .spec_inv  (c_spec_inv),
      .res       (c_res),
      .ovf       (c_ovf),
      .unf       (c_unf),
      .inv       (c_inv)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_vld <= 1'b0;
         res     <= '0;
         ovf     <= 1'b0;
         unf     <= 1'b0;
         inv     <= 1'b0;
      end else begin
         out_vld <= b_vld;
         if (b_vld) begin
            res <= c_res;
            ovf <= c_ovf;
            unf <= c_unf;
            inv <= c_inv;
         end
      end
   end
endmodule

// Port-level checker attached to every instance of the adder.
module fpa_chk #(
   parameter int EXP_W = 8,
   parameter int FRC_W = 23,
   parameter int LAT   = 3
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 in_vld,
   input logic                 out_vld,
   input logic [EXP_W+FRC_W:0] res,
   input logic                 ovf,
   input logic                 unf,
   input logic                 inv
);
   localparam logic [EXP_W-1:0] EXP_ONES = '1;
   localparam logic [EXP_W+FRC_W-1:0] QNAN_MAG = {EXP_ONES, 1'b1, {(FRC_W-1){1'b0}}};

   logic [2:0] hist;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) hist <= '0;
      else        hist <= {hist[1:0], in_vld};
   end

   logic [EXP_W-1:0] r_exp;
   logic [FRC_W-1:0] r_frc;
   assign r_exp = res[EXP_W+FRC_W-1:FRC_W];
   assign r_frc = res[FRC_W-1:0];

   assert_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
      out_vld == hist[LAT-1]);

   assert_flags_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
      out_vld |-> $countones({ovf, unf, inv}) <= 1);

   assert_ovf_is_inf_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (out_vld && ovf) |-> (r_exp == EXP_ONES && r_frc == '0));

   assert_unf_is_denorm_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (out_vld && unf) |-> (r_exp == '0 && r_frc != '0));

   assert_inv_gives_qnan_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (out_vld && inv) |-> (res == {1'b0, QNAN_MAG}));

   assert_nan_canonical_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (out_vld && r_exp == EXP_ONES && r_frc != '0) |-> (res == {1'b0, QNAN_MAG}));
endmodule

bind fp_add_sp fpa_chk #(
   .EXP_W (EXP_W),
   .FRC_W (FRC_W),
   .LAT   (1 + REG_ALIGN + REG_NORM)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .in_vld  (in_vld),
   .out_vld (out_vld),
   .res     (res),
   .ovf     (ovf),
   .unf     (unf),
   .inv     (inv)
);

// File: tb/tb_fp_add_sp.sv
module tb_fp_add_sp;
   localparam int CLK_PERIOD = 10;
   localparam int LAT        = 3;
   localparam int WD_CYCLES  = 150000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_vld = 1'b0;
   logic [31:0] op_a = '0;
   logic [31:0] op_b = '0;
   logic        op_sub = 1'b0;
   logic        out_vld;
   logic [31:0] res;
   logic        ovf, unf, inv;

   int n_cmp = 0;
   int n_bad = 0;
   int cyc   = 0;
   bit done  = 1'b0;

   logic [34:0] exp_q [$];
   string       tag_q [$];
   int          cyc_q [$];

   fp_add_sp dut (
      .clk     (clk),
      .rst_n   (rst_n),
      .in_vld  (in_vld),
      .op_a    (op_a),
      .op_b    (op_b),
      .op_sub  (op_sub),
      .out_vld (out_vld),
      .res     (res),
      .ovf     (ovf),
      .unf     (unf),
      .inv     (inv)
   );

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   // expected item: {inv, unf, ovf, result}
   function automatic logic [34:0] pk(logic [31:0] r, logic o, logic u, logic i);
      return {i, u, o, r};
   endfunction

   // exact reference: both operands placed on a wide integer grid of 2^-149
   function automatic logic [34:0] ref_add(logic [31:0] a, logic [31:0] b, logic sub);
      logic sa, sb, s;
      logic [7:0] ea, eb;
      logic [22:0] fa, fb;
      logic na, nb, ia, ib;
      logic [319:0] va, vb, mag, tmp, msk;
      logic [24:0] keep;
      int p, sh, e;
      logic g, rest, up;
      sa = a[31]; sb = b[31] ^ sub;
      ea = a[30:23]; eb = b[30:23];
      fa = a[22:0];  fb = b[22:0];
      na = (ea == 8'hFF) && (fa != 0);
      nb = (eb == 8'hFF) && (fb != 0);
      ia = (ea == 8'hFF) && (fa == 0);
      ib = (eb == 8'hFF) && (fb == 0);
      if (na || nb)
         return pk(32'h7FC00000, 1'b0, 1'b0, (na && !fa[22]) || (nb && !fb[22]));
      if (ia && ib && (sa != sb)) return pk(32'h7FC00000, 1'b0, 1'b0, 1'b1);
      if (ia) return pk({sa, 8'hFF, 23'd0}, 1'b0, 1'b0, 1'b0);
      if (ib) return pk({sb, 8'hFF, 23'd0}, 1'b0, 1'b0, 1'b0);
      va = 320'({ea != 0, fa}) << ((ea == 0) ? 0 : int'(ea) - 1);
      vb = 320'({eb != 0, fb}) << ((eb == 0) ? 0 : int'(eb) - 1);
      if (sa == sb) begin mag = va + vb; s = sa; end
      else if (va >= vb) begin mag = va - vb; s = sa; end
      else begin mag = vb - va; s = sb; end
      if (mag == 0) return pk({sa & sb, 31'd0}, 1'b0, 1'b0, 1'b0);
      p = 0;
      for (int i = 0; i < 320; i++) if (mag[i]) p = i;
      if (p <= 23) return pk({s, mag[30:0]}, 1'b0, !mag[23], 1'b0);
      sh = p - 23;
      tmp = mag >> sh;
      keep = tmp[24:0];
      g = mag[sh-1];
      msk = (320'(1) << (sh - 1)) - 320'(1);
      rest = |(mag & msk);
      up = g && (rest || keep[0]);
      keep = keep + 25'(up);
      if (keep[24]) begin keep = keep >> 1; sh++; end
      e = sh + 1;
      if (e >= 255) return pk({s, 8'hFF, 23'd0}, 1'b1, 1'b0, 1'b0);
      return pk({s, 8'(e), keep[22:0]}, 1'b0, 1'b0, 1'b0);
   endfunction

   // driver: one operation per call, back to back
   task automatic send(input logic [31:0] a, input logic [31:0] b, input logic s,
                       input logic [34:0] ex, input string tag);
      @(negedge clk);
      in_vld = 1'b1; op_a = a; op_b = b; op_sub = s;
      exp_q.push_back(ex);
      tag_q.push_back(tag);
      cyc_q.push_back(cyc);
   endtask

   task automatic send_ref(input logic [31:0] a, input logic [31:0] b, input logic s,
                           input string tag);
      send(a, b, s, ref_add(a, b, s), tag);
   endtask

   task automatic idle(input int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         in_vld = 1'b0;
      end
   endtask

   // monitor: pop and compare every result
   always @(negedge clk) begin
      if (rst_n && out_vld) begin
         logic [34:0] ex;
         string tg;
         int ic;
         n_cmp++;
         if (exp_q.size() == 0) begin
            n_bad++;
            $display("FAIL R1: unexpected result res=%h, expected no output", res);
         end else begin
            ex = exp_q.pop_front();
            tg = tag_q.pop_front();
            ic = cyc_q.pop_front();
            if ({inv, unf, ovf, res} !== ex) begin
               n_bad++;
               $display("FAIL %s: res=%h ovf=%b unf=%b inv=%b, expected res=%h ovf=%b unf=%b inv=%b",
                        tg, res, ovf, unf, inv, ex[31:0], ex[32], ex[33], ex[34]);
            end else if (cyc != ic + LAT) begin
               n_bad++;
               $display("FAIL R1: result arrived at cycle %0d, expected %0d", cyc, ic + LAT);
            end else if ($countones({ovf, unf, inv}) > 1) begin
               n_bad++;
               $display("FAIL R10: flags %b%b%b, expected at most one set", ovf, unf, inv);
            end
         end
      end
   end

   initial begin
      repeat (WD_CYCLES) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL R1: watchdog expired with %0d results outstanding, expected 0",
                  exp_q.size());
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] ra, rb;
      repeat (3) @(negedge clk);
      // R1: reset state
      n_cmp++;
      if (out_vld !== 1'b0 || res !== 32'd0 || {ovf, unf, inv} !== 3'b000) begin
         n_bad++;
         $display("FAIL R1: in reset out_vld=%b res=%h flags=%b%b%b, expected 0", out_vld, res, ovf, unf, inv);
      end
      @(negedge clk) rst_n = 1'b1;
      repeat (2) @(negedge clk);
      n_cmp++;
      if (out_vld !== 1'b0 || res !== 32'd0) begin
         n_bad++;
         $display("FAIL R1: after reset out_vld=%b res=%h, expected 0 and 0", out_vld, res);
      end

      // R2: plain sum and ties to even
      send(32'h3F800000, 32'h3F800000, 1'b0, pk(32'h40000000, 0, 0, 0), "R2");
      send(32'h3F800000, 32'h33800000, 1'b0, pk(32'h3F800000, 0, 0, 0), "R2");
      send(32'h3F800001, 32'h33800000, 1'b0, pk(32'h3F800002, 0, 0, 0), "R2");
      // R4: sticky above half rounds up, rounding carry renormalizes
      send(32'h3F800000, 32'h33800001, 1'b0, pk(32'h3F800001, 0, 0, 0), "R4");
      send(32'h4B7FFFFF, 32'h3F000000, 1'b0, pk(32'h4B800000, 0, 0, 0), "R4");
      // R3: subtraction and sign of the larger magnitude
      send(32'h40400000, 32'h3F800000, 1'b1, pk(32'h40000000, 0, 0, 0), "R3");
      send(32'h3F800000, 32'h40400000, 1'b1, pk(32'hC0000000, 0, 0, 0), "R3");
      idle(2);
      // R5: signed zeros
      send(32'h3F800000, 32'h3F800000, 1'b1, pk(32'h00000000, 0, 0, 0), "R5");
      send(32'hBF800000, 32'h3F800000, 1'b0, pk(32'h00000000, 0, 0, 0), "R5");
      send(32'h80000000, 32'h80000000, 1'b0, pk(32'h80000000, 0, 0, 0), "R5");
      send(32'h00000000, 32'h00000000, 1'b1, pk(32'h00000000, 0, 0, 0), "R5");
      // R6: denormals
      send(32'h00000001, 32'h00000001, 1'b0, pk(32'h00000002, 0, 1, 0), "R6");
      send(32'h00800000, 32'h00000001, 1'b1, pk(32'h007FFFFF, 0, 1, 0), "R6");
      send(32'h00400000, 32'h00400000, 1'b0, pk(32'h00800000, 0, 0, 0), "R6");
      // R7: overflow, including a tie that rounds past the largest value
      send(32'h7F7FFFFF, 32'h7F7FFFFF, 1'b0, pk(32'h7F800000, 1, 0, 0), "R7");
      send(32'hFF7FFFFF, 32'hFF7FFFFF, 1'b0, pk(32'hFF800000, 1, 0, 0), "R7");
      send(32'h7F7FFFFF, 32'h73000000, 1'b0, pk(32'h7F800000, 1, 0, 0), "R7");
      idle(1);
      // R8: infinities
      send(32'h7F800000, 32'h3F800000, 1'b0, pk(32'h7F800000, 0, 0, 0), "R8");
      send(32'h3F800000, 32'h7F800000, 1'b1, pk(32'hFF800000, 0, 0, 0), "R8");
      send(32'h7F800000, 32'h7F800000, 1'b1, pk(32'h7FC00000, 0, 0, 1), "R8");
      send(32'hFF800000, 32'h7F800000, 1'b0, pk(32'h7FC00000, 0, 0, 1), "R8");
      // R9: NaN operands, quiet and signaling
      send(32'h7FC00001, 32'h3F800000, 1'b0, pk(32'h7FC00000, 0, 0, 0), "R9");
      send(32'h3F800000, 32'hFF800001, 1'b0, pk(32'h7FC00000, 0, 0, 1), "R9");
      send(32'h7F800001, 32'h7F800000, 1'b1, pk(32'h7FC00000, 0, 0, 1), "R9");
      idle(3);

      // R2: random operands, back to back
      for (int n = 0; n < 3000; n++) send_ref($urandom, $urandom, 1'($urandom), "R2");
      idle(4);
      // R3: heavy cancellation
      for (int n = 0; n < 1000; n++) begin
         ra = $urandom;
         rb = ra ^ ($urandom & 32'h0000FFFF);
         if (n % 7 == 0) rb = ra;
         send_ref(ra, rb, 1'b1, "R3");
      end
      // R6: denormal range
      for (int n = 0; n < 500; n++)
         send_ref($urandom & 32'h80FFFFFF, $urandom & 32'h80FFFFFF, 1'($urandom), "R6");
      // R7: top of the range
      for (int n = 0; n < 500; n++)
         send_ref($urandom | 32'h7E000000, $urandom | 32'h7E000000, 1'($urandom), "R7");
      idle(1);

      while (exp_q.size() != 0) @(negedge clk);
      repeat (4) @(negedge clk);
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule